// File: doc/BRIEF.md
# Gated Asynchronous Character Transmitter

This block turns one byte at a time into an asynchronous serial character on a single line that rests high. A host writes a byte into a one-entry holding buffer; when the shifter is free, transmission is enabled and the attached modem pulls its active-low clear-to-send input low, the byte moves into the shifter. The shifter then sends a low start bit, the data bits starting with the least significant one, an optional parity bit and one or two high stop bits.

The block runs on a transmit clock that is a chosen multiple of the baud rate: every bit is held for 1, 16 or 64 clock cycles. Character length, parity and stop-bit count are configuration inputs. They are captured when a character starts, so they apply to whole characters. Two readiness levels are reported. One says the holding buffer can take a byte and the line is allowed to send, which suits an interrupt request. The other says the shifter holds no character at all. A byte waiting in the buffer while a character is shifting out starts right after the last stop bit, with no idle cycle between the two characters.

Top module: `serial_tx_gated`

## Requirements
- R1: After reset `txd` is 1 and `shifter_empty` is 1, and `txd` stays 1 whenever no character is shifting out.
- R2: A character is a 0 start bit followed by the data bits, least significant first; `fmt_len` values 0, 1, 2, 3 select 5, 6, 7, 8 data bits, and buffer bits above the selected length are not sent.
- R3: With `fmt_par_en` = 1 one parity bit follows the data bits; it makes the count of ones over the sent data bits and the parity bit even when `fmt_par_odd` = 0 and odd when `fmt_par_odd` = 1. With `fmt_par_en` = 0 no parity bit is sent.
- R4: The character ends with one high stop bit when `fmt_two_stop` = 0 and with two when it is 1.
- R5: Each bit lasts 1 clock cycle for `fmt_rate` = 00, 16 cycles for 01, and 64 cycles for 10 or 11.
- R6: `buf_ready` is 1 exactly when the holding buffer is empty, `tx_en` is 1 and `cts_n` is 0; an accepted write makes it 0 in the next cycle.
- R7: A character starts only while `tx_en` is 1 and `cts_n` is 0; a byte held while either condition is false waits in the buffer and the line stays idle.
- R8: `shifter_empty` is 0 from the first cycle of the start bit through the last cycle of the final stop bit, and 1 in the cycle after it when no byte follows.
- R9: A byte waiting in the buffer begins its start bit in the cycle right after the final stop bit of the previous character.
- R10: A write while the holding buffer is full is ignored: the held byte is the one sent and no extra character follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, baud rate times the selected factor |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable from the command settings |
| cts_n | input | 1 | Active-low clear-to-send from the modem |
| fmt_len | input | 2 | Data length: 0..3 select 5..8 bits |
| fmt_par_en | input | 1 | Send a parity bit |
| fmt_par_odd | input | 1 | 1 selects odd parity, 0 even |
| fmt_two_stop | input | 1 | 1 selects two stop bits |
| fmt_rate | input | 2 | Clock cycles per bit: 00 = 1, 01 = 16, 1x = 64 |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to be written |
| txd | output | 1 | Serial output line, idles high |
| buf_ready | output | 1 | Holding buffer free and sending allowed |
| shifter_empty | output | 1 | No character in the shifter |

## Verification
The end of a character's final stop bit and the move of the next byte from the holding buffer into the shifter fall in the same cycle. The bench provokes this by writing a second byte as soon as `buf_ready` returns while the first character is still on the line, then decoding both characters from `txd`. It judges the case by requiring the second start bit in the very cycle after the first character's last stop bit, with `shifter_empty` never rising between them, and both characters carrying their own data and framing.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    // Character geometry: start + data + parity + two stops at most.
    localparam int DATA_W    = 8;
    localparam int MIN_LEN   = 5;
    localparam int FRAME_W   = DATA_W + 4;
    localparam int CNT_W     = $clog2(FRAME_W + 1);
    localparam int PRESC_W   = 6;
    localparam int LEN_SEL_W = 2;
    localparam int RATE_W    = 2;

    typedef enum logic [RATE_W-1:0] {
        RATE_X1  = 2'b00,
        RATE_X16 = 2'b01,
        RATE_X64 = 2'b10,
        RATE_X64_ALT = 2'b11
    } rate_e;

    typedef struct packed {
        logic [LEN_SEL_W-1:0] len;
        logic                 par_en;
        logic                 par_odd;
        logic                 two_stop;
        logic [RATE_W-1:0]    rate;
    } fmt_t;

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_st_t;

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   left;
        logic [PRESC_W-1:0] last;
    } shift_st_t;

    // Last prescaler count of one bit time for a rate selection.
    function automatic logic [PRESC_W-1:0] rate_last(input logic [RATE_W-1:0] r);
        case (rate_e'(r))
            RATE_X1:  return PRESC_W'(0);
            RATE_X16: return PRESC_W'(15);
            default:  return PRESC_W'(63);
        endcase
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.full = 1'b0;
        end
        // A write only lands in an empty buffer; a full one drops it.
        if (wr_valid && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full = st_q.full;
    assign data = st_q.data;

endmodule

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer
    import sertx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               run,
    input  logic [PRESC_W-1:0] last,
    output logic               bit_end
);

    logic [PRESC_W-1:0] cnt_d, cnt_q;

    assign bit_end = run && (cnt_q == last);

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = bit_end ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  fmt_t              fmt,
    output logic              txd,
    output logic              busy,
    output logic              frame_done
);

    shift_st_t          st_d, st_q;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   total;
    logic               par;
    int                 nbits;
    logic               bit_end;

    // Assemble the whole character; positions past the stop bits stay 1.
    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        par      = fmt.par_odd;
        nbits    = MIN_LEN + int'(fmt.len);
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nbits) begin
                frame[1 + i] = data[i];
                par          = par ^ data[i];
            end
        end
        if (fmt.par_en) begin
            frame[1 + nbits] = par;
        end
        total = CNT_W'(2 + nbits + int'(fmt.par_en) + int'(fmt.two_stop));
    end

    sertx_bit_timer i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .run     (st_q.busy),
        .last    (st_q.last),
        .bit_end (bit_end)
    );

    assign frame_done = st_q.busy && bit_end && (st_q.left == CNT_W'(1));

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.busy = 1'b1;
            st_d.sh   = frame;
            st_d.left = total;
            st_d.last = rate_last(fmt.rate);
        end else if (st_q.busy && bit_end) begin
            if (st_q.left == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.sh   = '1;
            end else begin
                st_d.sh   = {1'b1, st_q.sh[FRAME_W-1:1]};
                st_d.left = st_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, sh: '1, left: '0, last: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign txd  = st_q.busy ? st_q.sh[0] : 1'b1;
    assign busy = st_q.busy;

endmodule

// File: rtl/serial_tx_gated.sv
module serial_tx_gated
    import sertx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_en,
    input  logic                 cts_n,
    input  logic [LEN_SEL_W-1:0] fmt_len,
    input  logic                 fmt_par_en,
    input  logic                 fmt_par_odd,
    input  logic                 fmt_two_stop,
    input  logic [RATE_W-1:0]    fmt_rate,
    input  logic                 wr_valid,
    input  logic [DATA_W-1:0]    wr_data,
    output logic                 txd,
    output logic                 buf_ready,
    output logic                 shifter_empty
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              busy;
    logic              frame_done;
    logic              send_ok;
    logic              start;
    fmt_t              fmt;

    assign fmt = '{len: fmt_len, par_en: fmt_par_en, par_odd: fmt_par_odd,
                   two_stop: fmt_two_stop, rate: fmt_rate};

    assign send_ok = tx_en && !cts_n;
    // Reload in the last stop cycle keeps characters gapless.
    assign start   = hold_full && send_ok && (!busy || frame_done);

    sertx_hold i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (start),
        .full     (hold_full),
        .data     (hold_data)
    );

    sertx_shifter i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start),
        .data       (hold_data),
        .fmt        (fmt),
        .txd        (txd),
        .busy       (busy),
        .frame_done (frame_done)
    );

    assign buf_ready     = !hold_full && send_ok;
    assign shifter_empty = !busy;

endmodule

// File: rtl/sertx_checks.sv
module sertx_checks (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic cts_n,
    input logic wr_valid,
    input logic txd,
    input logic buf_ready,
    input logic shifter_empty
);

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        shifter_empty |-> txd);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shifter_empty) |-> !txd);

    assert_stop_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shifter_empty) |-> $past(txd));

    assert_write_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && buf_ready) |=> !buf_ready);

    assert_start_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shifter_empty) |-> $past(tx_en && !cts_n));

endmodule

bind serial_tx_gated sertx_checks i_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_en         (tx_en),
    .cts_n         (cts_n),
    .wr_valid      (wr_valid),
    .txd           (txd),
    .buf_ready     (buf_ready),
    .shifter_empty (shifter_empty)
);

// File: tb/test_serial_tx_gated.sv
`timescale 1ns/1ps
module test_serial_tx_gated;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       cts_n = 1'b1;
    logic [1:0] fmt_len = 2'd3;
    logic       fmt_par_en = 1'b0;
    logic       fmt_par_odd = 1'b0;
    logic       fmt_two_stop = 1'b0;
    logic [1:0] fmt_rate = 2'd0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       txd, buf_ready, shifter_empty;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    serial_tx_gated i_serial_tx_gated (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cts_n(cts_n),
        .fmt_len(fmt_len), .fmt_par_en(fmt_par_en), .fmt_par_odd(fmt_par_odd),
        .fmt_two_stop(fmt_two_stop), .fmt_rate(fmt_rate),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .txd(txd), .buf_ready(buf_ready), .shifter_empty(shifter_empty)
    );

    // data, len sel, parity on, odd, two stops, rate
    localparam logic [14:0] VEC [8] = '{
        {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0},
        {8'h3C, 2'd3, 1'b1, 1'b0, 1'b1, 2'd0},
        {8'h3C, 2'd3, 1'b1, 1'b1, 1'b0, 2'd0},
        {8'hFF, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0},
        {8'hE6, 2'd1, 1'b1, 1'b1, 1'b1, 2'd0},
        {8'h80, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0},
        {8'h5A, 2'd3, 1'b0, 1'b0, 1'b0, 2'd1},
        {8'hC3, 2'd2, 1'b1, 1'b1, 1'b1, 2'd2}
    };

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int factor(input logic [1:0] r);
        return (r == 2'd0) ? 1 : (r == 2'd1) ? 16 : 64;
    endfunction

    // Expected line bits, built from the framing requirements.
    function automatic logic [11:0] exp_frame(input logic [7:0] d, input int nb, input bit pe,
                                              input bit po, input bit ts, output int total);
        logic [11:0] f;
        logic p;
        int idx;
        f = '1; f[0] = 1'b0; p = po;
        for (int i = 0; i < nb; i++) begin
            f[1 + i] = d[i];
            p = p ^ d[i];
        end
        idx = 1 + nb;
        if (pe) begin
            f[idx] = p;
            idx++;
        end
        total = idx + 1 + int'(ts);
        return f;
    endfunction

    task automatic set_fmt(input logic [14:0] v);
        fmt_len = v[6:5]; fmt_par_en = v[4]; fmt_par_odd = v[3];
        fmt_two_stop = v[2]; fmt_rate = v[1:0];
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk); wr_valid = 1'b1; wr_data = d;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    // Called at a negedge; samples each bit in its first cycle.
    task automatic rx_frame(input int fac, input int total, input bit must_now,
                            output logic [11:0] got, output bit started, output bit se_ok);
        int w = 0;
        got = '1; se_ok = 1'b1;
        if (!must_now) begin
            while (txd !== 1'b0 && w < 3000) begin
                @(negedge clk); w++;
            end
        end
        started = (txd === 1'b0);
        for (int b = 0; b < total; b++) begin
            got[b] = txd;
            if (shifter_empty !== 1'b0) se_ok = 1'b0;
            repeat (fac) @(negedge clk);
        end
    endtask

    task automatic frame_check(input logic [7:0] d, input logic [14:0] v, input bit must_now,
                               input string tag);
        logic [11:0] e, got, m;
        int total;
        bit st, se;
        e = exp_frame(d, 5 + int'(v[6:5]), v[4], v[3], v[2], total);
        rx_frame(factor(v[1:0]), total, must_now, got, st, se);
        m = 12'((13'd1 << total) - 1);
        check(st && ((got & m) == (e & m)), tag, {3'b0, st, got}, {4'b0001, e});
        check(se, {tag, " shifter_empty during frame (R8)"}, {15'b0, se}, 16'd1);
    endtask

    initial begin
        forever begin
            @(posedge clk); cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [14:0] v;
        repeat (3) @(negedge clk);
        check(txd === 1'b1 && shifter_empty === 1'b1, "R1 reset state",
              {14'b0, txd, shifter_empty}, 16'h3);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd === 1'b1 && shifter_empty === 1'b1 && buf_ready === 1'b0, "R1 idle after reset",
              {13'b0, txd, shifter_empty, buf_ready}, 16'h6);

        // R6: ready level follows enable and clear-to-send
        tx_en = 1'b1; cts_n = 1'b0; @(negedge clk);
        check(buf_ready === 1'b1, "R6 ready when enabled and clear", {15'b0, buf_ready}, 16'd1);
        cts_n = 1'b1; @(negedge clk);
        check(buf_ready === 1'b0, "R6 not ready without clear-to-send", {15'b0, buf_ready}, 16'd0);

        // Table of framing vectors
        foreach (VEC[k]) begin
            v = VEC[k];
            set_fmt(v);
            tx_en = 1'b1; cts_n = 1'b0;
            do_write(v[14:7]);
            frame_check(v[14:7], v, 1'b0, $sformatf("R2 R3 R4 R5 vector %0d", k));
            @(negedge clk);
            check(shifter_empty === 1'b1 && txd === 1'b1, "R8 empty after final stop",
                  {14'b0, shifter_empty, txd}, 16'h3);
        end

        // R7: clear-to-send high holds the byte
        v = {8'h5A, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0};
        set_fmt(v);
        cts_n = 1'b1; tx_en = 1'b1;
        do_write(8'h5A);
        begin
            bit idle = 1'b1;
            repeat (20) begin
                @(negedge clk);
                if (txd !== 1'b1 || shifter_empty !== 1'b1 || buf_ready !== 1'b0) idle = 1'b0;
            end
            check(idle, "R7 held while cts_n high", {15'b0, idle}, 16'd1);
        end
        cts_n = 1'b0;
        frame_check(8'h5A, v, 1'b0, "R7 sent after cts_n falls");

        // R7: transmit enable low holds the byte
        tx_en = 1'b0;
        do_write(8'h96);
        begin
            bit idle = 1'b1;
            repeat (20) begin
                @(negedge clk);
                if (txd !== 1'b1 || shifter_empty !== 1'b1 || buf_ready !== 1'b0) idle = 1'b0;
            end
            check(idle, "R7 held while tx_en low", {15'b0, idle}, 16'd1);
        end
        tx_en = 1'b1;
        frame_check(8'h96, v, 1'b0, "R7 sent after tx_en rises");

        // R10: second write into a full buffer is dropped
        cts_n = 1'b1;
        do_write(8'h11);
        do_write(8'h22);
        cts_n = 1'b0;
        frame_check(8'h11, v, 1'b0, "R10 held byte sent");
        begin
            bit idle = 1'b1;
            repeat (30) begin
                @(negedge clk);
                if (txd !== 1'b1 || shifter_empty !== 1'b1) idle = 1'b0;
            end
            check(idle, "R10 no extra character", {15'b0, idle}, 16'd1);
        end

        // R9: back-to-back characters with no gap
        v = {8'h00, 2'd3, 1'b1, 1'b1, 1'b1, 2'd0};
        set_fmt(v);
        do_write(8'hC9);
        fork
            frame_check(8'hC9, v, 1'b0, "R9 first character");
            begin
                @(negedge clk);
                while (buf_ready !== 1'b1) @(negedge clk);
                do_write(8'h37);
            end
        join
        frame_check(8'h37, v, 1'b1, "R9 second character starts at once");
        @(negedge clk);
        check(shifter_empty === 1'b1, "R8 empty after second character", {15'b0, shifter_empty}, 16'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule